// File: doc/BRIEF.md
# SHA Message Schedule Helper Unit

This unit evaluates the five two-operand helper steps that a vector crypto extension uses to build SHA-1 and SHA-256 message schedules and to fold the SHA-1 E word. Each operand is 128 bits wide and is split into four 32-bit lanes, with lane 3 in bits 127:96 and lane 0 in bits 31:0. The first operand acts as both destination and source. The second operand is a plain source. A 3-bit opcode selects the step.

Before any work is done, the unit checks the control state: the emulation flag, the OS extended-state enable, the task-switched flag, and the SHA feature-present bit. If the step may not run, the unit returns a fault code instead of a result.

A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` then goes low for one cycle while the lane network settles on registered operands. On the next edge the unit issues one of two responses:
- a `out_valid` pulse with a new `result`, or
- a `fault_valid` pulse with a nonzero `out_fault`.

Top module: `sha_msg_unit`

## Requirements
- R1: Opcode 0 (SHA-1 next-E): result lanes 2..0 equal second-operand lanes 2..0, and result lane 3 equals second-operand lane 3 plus first-operand lane 3 rotated left by 30.
- R2: Opcode 1 (SHA-1 message step 1): with first-operand lanes 3,2,1,0 taken as W0..W3 and second-operand lanes 3,2 taken as W4,W5, result lanes 3,2,1,0 are W0^W2, W1^W3, W2^W4 and W3^W5.
- R3: Opcode 2 (SHA-1 message step 2): result lane 3 = rotl1(A3^B2), lane 2 = rotl1(A2^B1), lane 1 = rotl1(A1^B0), and lane 0 = rotl1(A0 ^ result lane 3). Here A is the first operand and B the second.
- R4: Opcode 3 (SHA-256 message step 1): each result lane i equals first-operand lane i plus s0 of the word above it. The word above lane 3 is second-operand lane 0. s0(x) = rotr7 ^ rotr18 ^ (x>>3).
- R5: Opcode 4 (SHA-256 message step 2): lane 0 = A0+s1(B2), lane 1 = A1+s1(B3), lane 2 = A2+s1(lane 0), lane 3 = A3+s1(lane 1). s1(x) = rotr17 ^ rotr19 ^ (x>>10).
- R6: Fault code 1 (undefined opcode) is returned when the emulation flag is set, when the OS extended-state enable is clear, or when the SHA feature bit is clear. This code takes precedence over the task-switched flag.
- R7: Fault code 2 (device not available) is returned when none of the R6 conditions holds and the task-switched flag is set.
- R8: Opcodes 5, 6 and 7 return fault code 1.
- R9: On a fault the unit pulses `fault_valid` and does not pulse `out_valid`, and `result` keeps its previous value. On success the unit pulses `out_valid` with `out_fault` equal to 0.
- R10: After an accepting edge, `in_ready` is low for exactly one cycle. The response pulse appears after the second edge following acceptance and lasts one cycle.
- R11: All additions wrap modulo 2^32 within each lane, and no carry passes into a neighbouring lane.
- R12: After reset, `in_ready` is 1, both response pulses are 0, `out_fault` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| op_i | input | 3 | Step select (0..4 defined) |
| opa_i | input | 128 | First operand (destination/source), four 32-bit lanes |
| opb_i | input | 128 | Second operand, four 32-bit lanes |
| ctl_emul | input | 1 | Emulation flag |
| ctl_fxsr_en | input | 1 | OS extended-state enable |
| ctl_task_sw | input | 1 | Task-switched flag |
| feat_sha | input | 1 | SHA feature present |
| out_valid | output | 1 | One-cycle pulse: new result |
| fault_valid | output | 1 | One-cycle pulse: request faulted |
| out_fault | output | 2 | 0 none, 1 undefined opcode, 2 device not available |
| result | output | 128 | Result register |

## Verification
A wrong lane assignment or a broken chain term shows up in `result` at the very response that uses that step. The chained lanes (SHA-1 step 2 lane 0, SHA-256 step 2 lanes 2 and 3) depend on lanes computed in the same step, so an error there corrupts only those lanes, while the unchained lanes stay correct. A corrupted fault latch or busy flag shows up within two edges of acceptance, in one of these ways:
- a missing pulse;
- a doubled pulse;
- a success reported with a fault code;
- a result register that changes on a faulted request.

Randomised mixes of steps and control flags compare every response against a model written independently of the RTL.

// File: rtl/sha_msg_pkg.sv
package sha_msg_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;
  localparam int OP_W   = 3;
  localparam int FLT_W  = 2;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [OP_W-1:0] OP_S1_NEXTE = 3'd0;
  localparam logic [OP_W-1:0] OP_S1_MSGA  = 3'd1;
  localparam logic [OP_W-1:0] OP_S1_MSGB  = 3'd2;
  localparam logic [OP_W-1:0] OP_S2_MSGA  = 3'd3;
  localparam logic [OP_W-1:0] OP_S2_MSGB  = 3'd4;
  localparam logic [OP_W-1:0] OP_LAST     = OP_S2_MSGB;

  localparam logic [FLT_W-1:0] FLT_NONE     = 2'd0;
  localparam logic [FLT_W-1:0] FLT_UNDEF    = 2'd1;
  localparam logic [FLT_W-1:0] FLT_NOTAVAIL = 2'd2;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/sha_msg_gate.sv
module sha_msg_gate
  import sha_msg_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic             emul_i,
  input  logic             fxsr_en_i,
  input  logic             task_sw_i,
  input  logic             feat_i,
  output logic [FLT_W-1:0] fault_o
);
  logic op_unknown;
  logic undef_hit;

  assign op_unknown = (op_i > OP_LAST);
  assign undef_hit  = emul_i | ~fxsr_en_i | ~feat_i | op_unknown;

  always_comb begin
    if (undef_hit)      fault_o = FLT_UNDEF;
    else if (task_sw_i) fault_o = FLT_NOTAVAIL;
    else                fault_o = FLT_NONE;
  end
endmodule

// File: rtl/sha1_lanes.sv
module sha1_lanes
  import sha_msg_pkg::*;
(
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] nexte_o,
  output logic [VEC_W-1:0] msga_o,
  output logic [VEC_W-1:0] msgb_o,
  output word_t            chain_w16_o
);
  word_t a [LANES];
  word_t b [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign a[i] = a_i[i*WORD_W +: WORD_W];
    assign b[i] = b_i[i*WORD_W +: WORD_W];
  end

  word_t e_sum;
  assign e_sum   = b[3] + rotl(a[3], 30);
  assign nexte_o = {e_sum, b[2], b[1], b[0]};

  // Window W0..W5: first operand high-to-low, then two top lanes of second
  word_t win [6];
  assign win[0] = a[3];
  assign win[1] = a[2];
  assign win[2] = a[1];
  assign win[3] = a[0];
  assign win[4] = b[3];
  assign win[5] = b[2];

  for (genvar k = 0; k < LANES; k++) begin : g_msga
    assign msga_o[(LANES-1-k)*WORD_W +: WORD_W] = win[k] ^ win[k+2];
  end

  word_t w16, w17, w18, w19;
  assign w16 = rotl(a[3] ^ b[2], 1);
  assign w17 = rotl(a[2] ^ b[1], 1);
  assign w18 = rotl(a[1] ^ b[0], 1);
  assign w19 = rotl(a[0] ^ w16, 1);

  assign msgb_o      = {w16, w17, w18, w19};
  assign chain_w16_o = w16;
endmodule

// File: rtl/sha256_lanes.sv
module sha256_lanes
  import sha_msg_pkg::*;
(
  input  logic [VEC_W-1:0]    a_i,
  input  word_t               b_lo_i,
  input  logic [2*WORD_W-1:0] b_hi_i,
  output logic [VEC_W-1:0]    msga_o,
  output logic [VEC_W-1:0]    msgb_o,
  output word_t               chain_w16_o
);
  word_t a [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign a[i] = a_i[i*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_msga
    word_t above;
    if (i == LANES-1) begin : g_top
      assign above = b_lo_i;
    end else begin : g_mid
      assign above = a[i+1];
    end
    assign msga_o[i*WORD_W +: WORD_W] = a[i] + sig0(above);
  end

  word_t b2, b3, w16, w17, w18, w19;
  assign b2  = b_hi_i[0 +: WORD_W];
  assign b3  = b_hi_i[WORD_W +: WORD_W];
  assign w16 = a[0] + sig1(b2);
  assign w17 = a[1] + sig1(b3);
  assign w18 = a[2] + sig1(w16);
  assign w19 = a[3] + sig1(w17);

  assign msgb_o      = {w19, w18, w17, w16};
  assign chain_w16_o = w16;
endmodule

// File: rtl/sha_msg_unit.sv
module sha_msg_unit
  import sha_msg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  op_i,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  input  logic             ctl_emul,
  input  logic             ctl_fxsr_en,
  input  logic             ctl_task_sw,
  input  logic             feat_sha,
  output logic             out_valid,
  output logic             fault_valid,
  output logic [FLT_W-1:0] out_fault,
  output logic [VEC_W-1:0] result
);
  logic             busy;
  logic [OP_W-1:0]  op_q;
  logic [VEC_W-1:0] a_q, b_q;
  logic [FLT_W-1:0] flt_q;

  logic             accept;
  logic             finish_ok;
  logic             finish_flt;
  logic [FLT_W-1:0] gate_flt;

  logic [VEC_W-1:0] s1_nexte, s1_msga, s1_msgb, s2_msga, s2_msgb;
  word_t            s1_chain, s2_chain;
  logic [VEC_W-1:0] sel_res;

  assign in_ready   = ~busy;
  assign accept     = in_valid & in_ready;
  assign finish_ok  = busy & (flt_q == FLT_NONE);
  assign finish_flt = busy & (flt_q != FLT_NONE);

  sha_msg_gate u_gate (
    .op_i      (op_i),
    .emul_i    (ctl_emul),
    .fxsr_en_i (ctl_fxsr_en),
    .task_sw_i (ctl_task_sw),
    .feat_i    (feat_sha),
    .fault_o   (gate_flt)
  );

  sha1_lanes u_sha1 (
    .a_i         (a_q),
    .b_i         (b_q),
    .nexte_o     (s1_nexte),
    .msga_o      (s1_msga),
    .msgb_o      (s1_msgb),
    .chain_w16_o (s1_chain)
  );

  sha256_lanes u_sha256 (
    .a_i         (a_q),
    .b_lo_i      (b_q[0 +: WORD_W]),
    .b_hi_i      (b_q[2*WORD_W +: 2*WORD_W]),
    .msga_o      (s2_msga),
    .msgb_o      (s2_msgb),
    .chain_w16_o (s2_chain)
  );

  always_comb begin
    case (op_q)
      OP_S1_NEXTE: sel_res = s1_nexte;
      OP_S1_MSGA:  sel_res = s1_msga;
      OP_S1_MSGB:  sel_res = s1_msgb;
      OP_S2_MSGA:  sel_res = s2_msga;
      OP_S2_MSGB:  sel_res = s2_msgb;
      default:     sel_res = result;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      op_q        <= '0;
      a_q         <= '0;
      b_q         <= '0;
      flt_q       <= FLT_NONE;
      out_valid   <= 1'b0;
      fault_valid <= 1'b0;
      out_fault   <= FLT_NONE;
      result      <= '0;
    end else begin
      out_valid   <= 1'b0;
      fault_valid <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        op_q  <= op_i;
        a_q   <= opa_i;
        b_q   <= opb_i;
        flt_q <= gate_flt;
      end else if (busy) begin
        busy      <= 1'b0;
        out_fault <= flt_q;
        if (finish_ok) begin
          result    <= sel_res;
          out_valid <= 1'b1;
        end
        if (finish_flt) fault_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sha_msg_unit_chk.sv
module sha_msg_unit_chk
  import sha_msg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             fault_valid,
  input logic [FLT_W-1:0] out_fault,
  input logic [VEC_W-1:0] result
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && fault_valid)); // R9

  AST_FAULT_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $stable(result)); // R9

  AST_OK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fault == FLT_NONE)); // R9

  AST_FLT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (out_fault != FLT_NONE)); // R6

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R10

  AST_RESPONSE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 (out_valid || fault_valid)); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || fault_valid) |-> $past(!in_ready)); // R10
endmodule

bind sha_msg_unit sha_msg_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .fault_valid (fault_valid),
  .out_fault   (out_fault),
  .result      (result)
);

// File: tb/sim_sha_msg_unit.sv
module sim_sha_msg_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   op_i = '0;
  logic [127:0] opa_i = '0, opb_i = '0;
  logic         ctl_emul = 1'b0, ctl_fxsr_en = 1'b1, ctl_task_sw = 1'b0, feat_sha = 1'b1;
  logic         out_valid, fault_valid;
  logic [1:0]   out_fault;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic [1:0]   flt;
    string        tag;
  } item_t;
  item_t sb[$];
  logic [127:0] model_prev = '0;

  always #2 clk = ~clk;

  sha_msg_unit u0 (.*);

  function automatic logic [31:0] mrol(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} << n;
    return t[63:32];
  endfunction
  function automatic logic [31:0] mror(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction
  function automatic logic [31:0] ms0(input logic [31:0] x);
    return mror(x, 18) ^ (x >> 3) ^ mror(x, 7);
  endfunction
  function automatic logic [31:0] ms1(input logic [31:0] x);
    return (x >> 10) ^ mror(x, 19) ^ mror(x, 17);
  endfunction
  function automatic logic [31:0] ln(input logic [127:0] v, input int i);
    return v[32*i +: 32];
  endfunction

  function automatic logic [127:0] model(input logic [2:0] op, input logic [127:0] a, input logic [127:0] b);
    logic [31:0] r0, r1, r2, r3;
    r0 = 0; r1 = 0; r2 = 0; r3 = 0;
    case (op)
      3'd0: begin r0 = ln(b,0); r1 = ln(b,1); r2 = ln(b,2); r3 = ln(b,3) + mrol(ln(a,3), 30); end
      3'd1: begin
        r3 = ln(a,1) ^ ln(a,3); r2 = ln(a,0) ^ ln(a,2);
        r1 = ln(b,3) ^ ln(a,1); r0 = ln(b,2) ^ ln(a,0);
      end
      3'd2: begin
        r3 = mrol(ln(b,2) ^ ln(a,3), 1); r2 = mrol(ln(b,1) ^ ln(a,2), 1);
        r1 = mrol(ln(b,0) ^ ln(a,1), 1); r0 = mrol(r3 ^ ln(a,0), 1);
      end
      3'd3: begin
        r3 = ln(a,3) + ms0(ln(b,0)); r2 = ln(a,2) + ms0(ln(a,3));
        r1 = ln(a,1) + ms0(ln(a,2)); r0 = ln(a,0) + ms0(ln(a,1));
      end
      default: begin
        r0 = ln(a,0) + ms1(ln(b,2)); r1 = ln(a,1) + ms1(ln(b,3));
        r2 = ln(a,2) + ms1(r0);      r3 = ln(a,3) + ms1(r1);
      end
    endcase
    return {r3, r2, r1, r0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [127:0] a, input logic [127:0] b,
                       input bit em, input bit fx, input bit ts, input bit ft, input string tag);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    if (em || !fx || !ft || op > 3'd4) it.flt = 2'd1;
    else if (ts)                        it.flt = 2'd2;
    else                                it.flt = 2'd0;
    it.res = (it.flt == 2'd0) ? model(op, a, b) : model_prev;
    model_prev = it.res;
    it.tag = tag;
    sb.push_back(it);
    op_i = op; opa_i = a; opb_i = b;
    ctl_emul = em; ctl_fxsr_en = fx; ctl_task_sw = ts; feat_sha = ft;
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 ready low after accept", {127'd0, in_ready}, 128'd0);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || fault_valid)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected response", {126'd0, out_valid, fault_valid}, 128'd0);
      end else begin
        item_t e;
        e = sb.pop_front();
        chk(fault_valid == (e.flt != 2'd0) && out_valid == (e.flt == 2'd0),
            {e.tag, " R9 pulse kind"}, {126'd0, out_valid, fault_valid}, {127'd0, e.flt == 2'd0});
        chk(out_fault == e.flt, {e.tag, " fault code"}, {126'd0, out_fault}, {126'd0, e.flt});
        chk(result == e.res, {e.tag, " result"}, result, e.res);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] va, vb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && fault_valid == 1'b0 && out_fault == 2'd0 && result == '0,
        "R12 reset state", result, 128'd0);
    rst_n = 1'b1;

    va = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    vb = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    issue(3'd0, va, vb, 0, 1, 0, 1, "R1 next-E");
    issue(3'd0, {32'hffff_ffff, 96'h0}, {32'hffff_ffff, 96'h0}, 0, 1, 0, 1, "R11 next-E wrap");
    issue(3'd1, va, vb, 0, 1, 0, 1, "R2 sha1 step1");
    issue(3'd2, va, vb, 0, 1, 0, 1, "R3 sha1 step2");
    issue(3'd2, 128'h8000_0000_0000_0001_0000_0000_dead_beef, 128'h0, 0, 1, 0, 1, "R3 sha1 step2 chain");
    issue(3'd3, va, vb, 0, 1, 0, 1, "R4 sha256 step1");
    issue(3'd3, {128{1'b1}}, {128{1'b1}}, 0, 1, 0, 1, "R11 sha256 step1 wrap");
    issue(3'd4, va, vb, 0, 1, 0, 1, "R5 sha256 step2");
    issue(3'd4, {128{1'b1}}, 128'hcafe_f00d_0bad_beef_0000_0000_0000_0000, 0, 1, 0, 1, "R5 R11 sha256 step2 chain");
    issue(3'd1, vb, va, 1, 1, 0, 1, "R6 R9 emul flag");
    issue(3'd1, vb, va, 0, 0, 0, 1, "R6 R9 fxsr clear");
    issue(3'd1, vb, va, 0, 1, 0, 0, "R6 R9 feature absent");
    issue(3'd1, vb, va, 1, 1, 1, 1, "R6 precedence over task-switch");
    issue(3'd2, vb, va, 0, 1, 1, 1, "R7 R9 task-switched");
    issue(3'd5, va, vb, 0, 1, 0, 1, "R8 opcode 5");
    issue(3'd6, va, vb, 0, 1, 0, 1, "R8 opcode 6");
    issue(3'd7, va, vb, 0, 1, 1, 1, "R8 opcode 7");
    for (int n = 0; n < 40; n++) begin
      logic [2:0] rop;
      bit rem, rfx, rts, rft;
      rop = 3'($urandom_range(0, 7));
      va  = {$urandom, $urandom, $urandom, $urandom};
      vb  = {$urandom, $urandom, $urandom, $urandom};
      rem = ($urandom_range(0, 7) == 0);
      rfx = ($urandom_range(0, 7) != 0);
      rts = ($urandom_range(0, 7) == 0);
      rft = ($urandom_range(0, 7) != 0);
      issue(rop, va, vb, rem, rfx, rts, rft, "R1 R2 R3 R4 R5 R6 R7 R8 mixed");
    end
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R10 all responses seen", 128'(sb.size()), 128'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule